// File: doc/BRIEF.md
# Vector Operand Swizzle and Write-Mask Unit

This block is one datapath stage of a four-lane shader ALU. Each lane holds an IEEE single-precision value, and the lanes are named x, y, z and w. The stage takes three decoded instruction words and three source vectors read from a register file. From these it builds up to three operand vectors. Each operand lane can take any lane of its source, or the constant 0.0 or 1.0, and the sign of the chosen value can be flipped lane by lane. The selector fields for one source may lie in two different instruction words, and the stage puts them back together.

On the write side, the stage takes a result vector from the ALU and the old contents of the destination register. It merges the two under a per-lane write mask, clamps the written lanes to [0.0, 1.0] when the instruction asks for it, and registers the merged vector for writeback. The stage also raises two kinds of flag:
- a selector code that does not exist;
- a scalar opcode whose first operand is not a replicated swizzle.

The ALU arithmetic and the register file are outside this block.

Top module: `opnd_swizzle_unit`

## Requirements
- R1: A lane selector is a 4-bit nibble. Bits 2:0 pick the value: 0, 1, 2 and 3 take source lane x, y, z and w, 4 gives +0.0 (0x00000000) and 5 gives 1.0 (0x3F800000). A vector packs lane x in bits 31:0, y in 63:32, z in 95:64 and w in 127:96.
- R2: When bit 3 of a nibble is set, bit 31 of the selected value is inverted, and this applies to the constants too. Bits 30:0 are unchanged.
- R3: Selector nibble positions:
  - Source 0 lanes x, y, z and w use word1 bits 31:28, 27:24, 23:20 and 19:16.
  - Source 1 lanes x and y use word1 bits 7:4 and 3:0, and its lanes z and w use word2 bits 31:28 and 27:24.
  - Source 2 lanes x, y, z and w use word2 bits 15:12, 11:8, 7:4 and 3:0.
- R4: Selector codes 6 and 7 behave like code 4, so they give 0.0 with the negate bit applied. Any such code in a source sets that source's bit of `sel_illegal` (bit 0 for source 0, and so on).
- R5: The opcode is word0 bits 28:24. For the scalar opcodes 9 through 12, `scalar_nonrep` is high unless all four source 0 codes (bits 2:0) are equal and lie in 0..3; the negate bits are ignored in this test. For every other opcode, `scalar_nonrep` is low.
- R6: The write mask is word0 bits 13:10, with bit 10 for lane x up to bit 13 for lane w. A lane whose mask bit is clear takes `old_vec` unchanged.
- R7: When word0 bit 22 is set, each written lane is clamped:
  - any value with the sign bit set, and any NaN, becomes +0.0;
  - values at or above 1.0, including +infinity, become 1.0;
  - all other values pass through unchanged.
  When bit 22 is clear, written lanes pass through raw.
- R8: The edge where `res_valid` is high loads the merged vector into `wb_vec`, and `wb_valid` goes high on that same edge. On an edge where `res_valid` is low, `wb_valid` goes low and `wb_vec` holds its value.
- R9: During reset, `wb_valid` and `wb_vec` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| word0 | input | 32 | Instruction word with the opcode, saturate bit and write mask |
| word1 | input | 32 | Instruction word with the source 0 selectors and source 1 x/y selectors |
| word2 | input | 32 | Instruction word with the source 1 z/w selectors and source 2 selectors |
| src0_vec | input | 128 | Source 0 vector from the register file |
| src1_vec | input | 128 | Source 1 vector |
| src2_vec | input | 128 | Source 2 vector |
| op0_vec | output | 128 | Swizzled source 0 operand |
| op1_vec | output | 128 | Swizzled source 1 operand |
| op2_vec | output | 128 | Swizzled source 2 operand |
| sel_illegal | output | 3 | Per-source flag for selector code 6 or 7 |
| scalar_nonrep | output | 1 | Scalar opcode with a non-replicated source 0 swizzle |
| res_valid | input | 1 | ALU result valid |
| res_vec | input | 128 | ALU result vector |
| old_vec | input | 128 | Current destination register value |
| wb_valid | output | 1 | Registered writeback valid |
| wb_vec | output | 128 | Registered merged writeback vector |

## Verification
The selector sweep tries all 16 nibble codes in every lane of every source. Each source lane carries a distinct value with a clear sign bit, so a wrong field position, a wrong lane pick, a missing negate or a wrong illegal-flag bit each shows up as a different value. The scalar sweep crosses all 32 opcodes with replicated, negated-replicated and non-replicated source 0 patterns. This separates the scalar opcode range from the rest and shows that negate bits do not affect the replication test. The merge sweep runs all 16 masks, with saturation on and off, over result sets that hold negative values, -0.0, NaN of both signs, +infinity, exactly 1.0, the values just below and just above 1.0, and a denormal. The old vector has the sign bit set, so a kept lane that was wrongly clamped would show. After each capture, the result changes while `res_valid` is low, which shows that the register holds its value.

// File: rtl/swz_pkg.sv
package swz_pkg;

   localparam int LANES = 4;
   localparam int NSRC  = 3;
   localparam int SEL_W = 4;

   localparam logic [31:0] FP_ONE  = 32'h3F80_0000;
   localparam logic [4:0]  OPC_SCALAR_LO = 5'd9;
   localparam logic [4:0]  OPC_SCALAR_HI = 5'd12;

   typedef enum logic [2:0] {
      PICK_X    = 3'd0,
      PICK_Y    = 3'd1,
      PICK_Z    = 3'd2,
      PICK_W    = 3'd3,
      PICK_ZERO = 3'd4,
      PICK_ONE  = 3'd5,
      PICK_BAD6 = 3'd6,
      PICK_BAD7 = 3'd7
   } pick_e;

   typedef struct packed {
      logic  neg;
      pick_e pick;
   } chsel_t;

   // clamp a single-precision value into [0.0, 1.0]
   function automatic logic [31:0] clamp_unit(input logic [31:0] v);
      logic is_nan;
      is_nan = (v[30:23] == 8'hFF) && (v[22:0] != 23'd0);
      if (v[31] || is_nan)
         return 32'd0;
      else if (v >= FP_ONE)
         return FP_ONE;
      else
         return v;
   endfunction

endpackage

// File: rtl/swz_field_map.sv
module swz_field_map
   import swz_pkg::*;
(
   input  logic [31:0]                  word1,
   input  logic [31:0]                  word2,
   output chsel_t [NSRC-1:0][LANES-1:0] sel
);

   // source 0 lives entirely in the upper half of word1
   for (genvar l = 0; l < LANES; l++) begin : g_s0
      assign sel[0][l] = chsel_t'(word1[31-SEL_W*l -: SEL_W]);
   end

   // source 1 straddles the word1/word2 boundary
   assign sel[1][0] = chsel_t'(word1[7:4]);
   assign sel[1][1] = chsel_t'(word1[3:0]);
   assign sel[1][2] = chsel_t'(word2[31:28]);
   assign sel[1][3] = chsel_t'(word2[27:24]);

   // source 2 lives in the lower half of word2
   for (genvar l = 0; l < LANES; l++) begin : g_s2
      assign sel[2][l] = chsel_t'(word2[15-SEL_W*l -: SEL_W]);
   end

endmodule

// File: rtl/swz_lane_route.sv
module swz_lane_route
   import swz_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  chsel_t [LANES-1:0]         sel,
   input  logic [LANES*DATA_W-1:0]    vec,
   output logic [LANES*DATA_W-1:0]    op,
   output logic                       illegal
);

   localparam logic [DATA_W-1:0] ONE_VAL = DATA_W'(FP_ONE);

   logic [LANES-1:0] bad;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [DATA_W-1:0] raw;
      logic              bad_l;

      always_comb begin
         bad_l = 1'b0;
         case (sel[l].pick)
            PICK_X:    raw = vec[0*DATA_W +: DATA_W];
            PICK_Y:    raw = vec[1*DATA_W +: DATA_W];
            PICK_Z:    raw = vec[2*DATA_W +: DATA_W];
            PICK_W:    raw = vec[3*DATA_W +: DATA_W];
            PICK_ZERO: raw = '0;
            PICK_ONE:  raw = ONE_VAL;
            default: begin
               raw   = '0;
               bad_l = 1'b1;
            end
         endcase
      end

      assign bad[l] = bad_l;
      assign op[l*DATA_W +: DATA_W] = {raw[DATA_W-1] ^ sel[l].neg, raw[DATA_W-2:0]};
   end

   assign illegal = |bad;

endmodule

// File: rtl/swz_wmask_merge.sv
module swz_wmask_merge
   import swz_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter bit SAT_SUPPORT = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    res_valid,
   input  logic [LANES-1:0]        mask,
   input  logic                    sat_en,
   input  logic [LANES*DATA_W-1:0] res_vec,
   input  logic [LANES*DATA_W-1:0] old_vec,
   output logic                    wb_valid,
   output logic [LANES*DATA_W-1:0] wb_vec
);

   logic [LANES*DATA_W-1:0] merged;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [DATA_W-1:0] r;
      logic [DATA_W-1:0] shaped;

      assign r = res_vec[l*DATA_W +: DATA_W];

      if (SAT_SUPPORT) begin : g_sat
         assign shaped = sat_en ? clamp_unit(r) : r;
      end else begin : g_raw
         logic unused_sat;
         assign unused_sat = sat_en;
         assign shaped     = r;
      end

      assign merged[l*DATA_W +: DATA_W] = mask[l] ? shaped : old_vec[l*DATA_W +: DATA_W];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wb_valid <= 1'b0;
         wb_vec   <= '0;
      end else begin
         wb_valid <= res_valid;
         if (res_valid)
            wb_vec <= merged;
      end
   end

endmodule

// File: rtl/opnd_swizzle_unit.sv
module opnd_swizzle_unit
   import swz_pkg::*;
#(
   parameter int DATA_W      = 32,
   parameter bit SAT_SUPPORT = 1'b1,
   localparam int VEC_W      = LANES * DATA_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [31:0]      word0,
   input  logic [31:0]      word1,
   input  logic [31:0]      word2,
   input  logic [VEC_W-1:0] src0_vec,
   input  logic [VEC_W-1:0] src1_vec,
   input  logic [VEC_W-1:0] src2_vec,
   output logic [VEC_W-1:0] op0_vec,
   output logic [VEC_W-1:0] op1_vec,
   output logic [VEC_W-1:0] op2_vec,
   output logic [NSRC-1:0]  sel_illegal,
   output logic             scalar_nonrep,
   input  logic             res_valid,
   input  logic [VEC_W-1:0] res_vec,
   input  logic [VEC_W-1:0] old_vec,
   output logic             wb_valid,
   output logic [VEC_W-1:0] wb_vec
);

   if (DATA_W != 32) begin : g_bad_width
      $error("opnd_swizzle_unit: lanes must be single precision (DATA_W=32)");
   end
   if (LANES != 4) begin : g_bad_lanes
      $error("opnd_swizzle_unit: selector layout assumes four lanes");
   end

   chsel_t [NSRC-1:0][LANES-1:0] sel;
   logic   [NSRC-1:0][VEC_W-1:0] src_a;
   logic   [NSRC-1:0][VEC_W-1:0] op_a;

   assign src_a[0] = src0_vec;
   assign src_a[1] = src1_vec;
   assign src_a[2] = src2_vec;

   swz_field_map u_map (
      .word1 (word1),
      .word2 (word2),
      .sel   (sel)
   );

   for (genvar s = 0; s < NSRC; s++) begin : g_src
      swz_lane_route #(.DATA_W(DATA_W)) u_route (
         .sel     (sel[s]),
         .vec     (src_a[s]),
         .op      (op_a[s]),
         .illegal (sel_illegal[s])
      );
   end

   assign op0_vec = op_a[0];
   assign op1_vec = op_a[1];
   assign op2_vec = op_a[2];

   // scalar opcodes need a replicated first operand
   logic [4:0] opc;
   logic       opc_scalar;
   logic       replicated;

   assign opc        = word0[28:24];
   assign opc_scalar = (opc >= OPC_SCALAR_LO) && (opc <= OPC_SCALAR_HI);

   always_comb begin
      replicated = (sel[0][0].pick <= PICK_W);
      for (int l = 1; l < LANES; l++)
         replicated = replicated && (sel[0][l].pick == sel[0][0].pick);
   end

   assign scalar_nonrep = opc_scalar && !replicated;

   swz_wmask_merge #(.DATA_W(DATA_W), .SAT_SUPPORT(SAT_SUPPORT)) u_merge (
      .clk       (clk),
      .rst_n     (rst_n),
      .res_valid (res_valid),
      .mask      (word0[13:10]),
      .sat_en    (word0[22]),
      .res_vec   (res_vec),
      .old_vec   (old_vec),
      .wb_valid  (wb_valid),
      .wb_vec    (wb_vec)
   );

   logic unused_word0;
   assign unused_word0 = ^{word0[31:29], word0[23], word0[21:14], word0[9:0]};

endmodule

// File: rtl/opnd_swizzle_checker.sv
module opnd_swizzle_checker
   import swz_pkg::*;
(
   input logic         clk,
   input logic         rst_n,
   input logic [31:0]  word0,
   input logic [31:0]  word1,
   input logic [127:0] op0_vec,
   input logic [2:0]   sel_illegal,
   input logic         scalar_nonrep,
   input logic         res_valid,
   input logic [127:0] old_vec,
   input logic         wb_valid,
   input logic [127:0] wb_vec
);

   assert_wb_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> wb_valid);

   assert_wb_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !res_valid |=> (!wb_valid && $stable(wb_vec)));

   for (genvar l = 0; l < 4; l++) begin : g_lane
      assert_keep_old_R6: assert property (@(posedge clk) disable iff (!rst_n)
         (res_valid && !word0[10+l]) |=> (wb_vec[32*l +: 32] == $past(old_vec[32*l +: 32])));

      assert_sat_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
         (res_valid && word0[22] && word0[10+l]) |=>
            (!wb_vec[32*l+31] && (wb_vec[32*l +: 32] <= FP_ONE)));
   end

   assert_illegal_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (word1[30:29] == 2'b11) |-> (sel_illegal[0] && (op0_vec[30:0] == 31'd0)));

   assert_scalar_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (word0[28:24] < 5'd9 || word0[28:24] > 5'd12) |-> !scalar_nonrep);

endmodule

bind opnd_swizzle_unit opnd_swizzle_checker u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .word0         (word0),
   .word1         (word1),
   .op0_vec       (op0_vec),
   .sel_illegal   (sel_illegal),
   .scalar_nonrep (scalar_nonrep),
   .res_valid     (res_valid),
   .old_vec       (old_vec),
   .wb_valid      (wb_valid),
   .wb_vec        (wb_vec)
);

// File: tb/tb_opnd_swizzle_unit.sv
module tb_opnd_swizzle_unit;

   localparam int CLK_PERIOD = 10;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [31:0]  word0 = '0, word1 = '0, word2 = '0;
   logic [127:0] src0_vec = '0, src1_vec = '0, src2_vec = '0;
   logic [127:0] op0_vec, op1_vec, op2_vec;
   logic [2:0]   sel_illegal;
   logic         scalar_nonrep;
   logic         res_valid = 1'b0;
   logic [127:0] res_vec = '0, old_vec = '0;
   logic         wb_valid;
   logic [127:0] wb_vec;

   int errors = 0;
   int checks = 0;
   bit done   = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   opnd_swizzle_unit dut (
      .clk(clk), .rst_n(rst_n), .word0(word0), .word1(word1), .word2(word2),
      .src0_vec(src0_vec), .src1_vec(src1_vec), .src2_vec(src2_vec),
      .op0_vec(op0_vec), .op1_vec(op1_vec), .op2_vec(op2_vec),
      .sel_illegal(sel_illegal), .scalar_nonrep(scalar_nonrep),
      .res_valid(res_valid), .res_vec(res_vec), .old_vec(old_vec),
      .wb_valid(wb_valid), .wb_vec(wb_vec)
   );

   task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [31:0] src_lane(input int s, input int l);
      return {8'h10 * 8'(s + 1) + 8'(l), 24'hA5C3E1};
   endfunction

   // expected operand lane from a nibble code (R1, R2, R4)
   function automatic logic [31:0] exp_lane(input int s, input logic [3:0] code);
      logic [31:0] v;
      if (code[2:0] < 3'd4)      v = src_lane(s, int'(code[1:0]));
      else if (code[2:0] == 3'd5) v = 32'h3F80_0000;
      else                        v = 32'h0;
      if (code[3]) v[31] = ~v[31];
      return v;
   endfunction

   // expected clamp (R7), written from exponent ranges
   function automatic logic [31:0] exp_clamp(input logic [31:0] v);
      if (v[30:23] == 8'd255 && v[22:0] != 0) return 32'h0;
      if (v[31])                              return 32'h0;
      if (v[30:23] >= 8'd127)                 return 32'h3F80_0000;
      return v;
   endfunction

   task automatic place(input int s, input int l, input logic [3:0] code,
                        inout logic [31:0] w1, inout logic [31:0] w2);
      // field positions from R3
      case (s)
         0: w1[31-4*l -: 4] = code;
         1: case (l)
               0: w1[7:4]   = code;
               1: w1[3:0]   = code;
               2: w2[31:28] = code;
               default: w2[27:24] = code;
            endcase
         default: w2[15-4*l -: 4] = code;
      endcase
   endtask

   initial begin : watchdog
      #(CLK_PERIOD * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=timeout expected=finish");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin : main
      logic [31:0] resset [3][4];
      resset[0] = '{32'hBFC0_0000, 32'h7FC0_0000, 32'h4000_0000, 32'h3F00_0000};
      resset[1] = '{32'h8000_0000, 32'h7F80_0000, 32'h3F80_0000, 32'h0000_0001};
      resset[2] = '{32'h3F7F_FFFF, 32'h3F80_0001, 32'hFFC0_0001, 32'h0000_0000};

      for (int s = 0; s < 3; s++)
         for (int l = 0; l < 4; l++) begin
            case (s)
               0: src0_vec[32*l +: 32] = src_lane(s, l);
               1: src1_vec[32*l +: 32] = src_lane(s, l);
               default: src2_vec[32*l +: 32] = src_lane(s, l);
            endcase
         end

      repeat (3) @(negedge clk);
      // R9: reset state
      chk(wb_valid == 1'b0, "R9 wb_valid in reset", 128'(wb_valid), 128'd0);
      chk(wb_vec == '0, "R9 wb_vec in reset", wb_vec, 128'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(wb_valid == 1'b0, "R9 wb_valid after reset", 128'(wb_valid), 128'd0);

      // R1 R2 R3 R4: every code in every lane of every source
      for (int s = 0; s < 3; s++)
         for (int l = 0; l < 4; l++)
            for (int c = 0; c < 16; c++) begin
               logic [31:0] w1, w2, act;
               logic [2:0]  exp_ill;
               w1 = '0; w2 = '0;
               place(s, l, 4'(c), w1, w2);
               word1 = w1; word2 = w2;
               #1;
               case (s)
                  0: act = op0_vec[32*l +: 32];
                  1: act = op1_vec[32*l +: 32];
                  default: act = op2_vec[32*l +: 32];
               endcase
               chk(act == exp_lane(s, 4'(c)), "R1/R2/R3 operand lane", 128'(act), 128'(exp_lane(s, 4'(c))));
               exp_ill = '0;
               if (c[2:0] >= 6) exp_ill[s] = 1'b1;
               chk(sel_illegal == exp_ill, "R4 illegal flag", 128'(sel_illegal), 128'(exp_ill));
               @(negedge clk);
            end

      // R5: scalar replication check across all opcodes
      word2 = '0;
      for (int p = 0; p < 7; p++)
         for (int opc = 0; opc < 32; opc++) begin
            logic [15:0] pat;
            bit          rep, exp_f;
            case (p)
               0: begin pat = 16'h0123; rep = 0; end
               1: begin pat = 16'h1111; rep = 1; end
               2: begin pat = 16'hA2A2; rep = 1; end
               3: begin pat = 16'h0004; rep = 0; end
               4: begin pat = 16'h5555; rep = 0; end
               5: begin pat = 16'h3333; rep = 1; end
               default: begin pat = 16'h6666; rep = 0; end
            endcase
            word1 = {pat, 16'h0000};
            word0 = {3'b000, 5'(opc), 24'h0};
            #1;
            exp_f = (opc >= 9 && opc <= 12) && !rep;
            chk(scalar_nonrep == exp_f, "R5 scalar_nonrep", 128'(scalar_nonrep), 128'(exp_f));
            @(negedge clk);
         end

      // R6 R7 R8: mask x saturate x result sets
      word1 = '0;
      for (int l = 0; l < 4; l++) old_vec[32*l +: 32] = 32'hDEAD_0000 + 32'(l);
      for (int rs = 0; rs < 3; rs++)
         for (int sat = 0; sat < 2; sat++)
            for (int m = 0; m < 16; m++) begin
               logic [127:0] exp_v, held;
               for (int l = 0; l < 4; l++) res_vec[32*l +: 32] = resset[rs][l];
               word0 = '0;
               word0[22] = sat[0];
               word0[13:10] = 4'(m);
               for (int l = 0; l < 4; l++) begin
                  if (!m[l])     exp_v[32*l +: 32] = old_vec[32*l +: 32];
                  else if (sat)  exp_v[32*l +: 32] = exp_clamp(resset[rs][l]);
                  else           exp_v[32*l +: 32] = resset[rs][l];
               end
               res_valid = 1'b1;
               @(negedge clk);
               res_valid = 1'b0;
               chk(wb_valid == 1'b1, "R8 wb_valid after capture", 128'(wb_valid), 128'd1);
               for (int l = 0; l < 4; l++) begin
                  if (!m[l])
                     chk(wb_vec[32*l +: 32] == exp_v[32*l +: 32], "R6 masked lane keeps old",
                         128'(wb_vec[32*l +: 32]), 128'(exp_v[32*l +: 32]));
                  else
                     chk(wb_vec[32*l +: 32] == exp_v[32*l +: 32], "R7 written lane value",
                         128'(wb_vec[32*l +: 32]), 128'(exp_v[32*l +: 32]));
               end
               held = wb_vec;
               res_vec = ~res_vec;
               @(negedge clk);
               chk(wb_valid == 1'b0, "R8 wb_valid drops", 128'(wb_valid), 128'd0);
               chk(wb_vec == held, "R8 wb_vec holds", wb_vec, held);
            end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule